// File: doc/BRIEF.md
# Compiler-Directed Issue Stall Controller

This block is the issue stage for a single instruction stream in an in-order pipeline. It never compares register names between instructions. The compiler attaches three control fields to every instruction:

- a stall code, which says how long to wait after this instruction before the next one may go;
- an optional barrier slot that this instruction marks as busy when it issues;
- a mask of barrier slots that must be idle before this instruction may issue.

The controller holds the instruction at its input until the timer has expired and every barrier named in its mask is idle. It then accepts the instruction and reports the issue one cycle later. The execution units return a one-cycle completion pulse that frees a barrier slot.

If the stall code is shorter than the real latency of the producing instruction, the controller does not detect it. It issues the consumer on schedule and raises no error. Correct operation depends entirely on the encoded stall counts and barrier bits.

Instructions arrive on a valid/ready handshake. An instruction is accepted in any cycle where `in_valid` and `in_ready` are both high. While `in_ready` is low, the producer must hold `in_valid` and every instruction field stable. `in_ready` depends only on the internal state and on the current `in_wait_mask`, never on `in_valid`. The completion input and the status output are plain signals with no handshake.

Top module: `issue_stall_ctrl`

## Requirements
- R1: After reset the stall timer is idle and all barrier slots are idle. `in_ready` is therefore high in the first cycle after reset for any wait mask, `bar_pending` is 0 and `iss_valid` is 0.
- R2: A stall code s in the range 1 to 15 on an instruction accepted in cycle t keeps `in_ready` low through cycle t+s-1. With no barrier blocking, the next instruction is accepted in cycle t+s, so code 1 allows back-to-back issue.
- R3: Stall code 0 means a long wait of DEFAULT_WAIT cycles (default 32). The next instruction can be accepted no earlier than DEFAULT_WAIT cycles after it.
- R4: An accepted instruction with `in_set_en`=1 and `in_set_idx` in the range 0..5 sets bit `in_set_idx` of `bar_pending` from the next cycle. Bits change only by such a set or by a completion pulse.
- R5: `in_ready` is low while `in_wait_mask & bar_pending` is nonzero. Bit i of the mask refers to barrier slot i.
- R6: A pulse with `done_valid`=1 clears bit `done_idx` of `bar_pending` in the next cycle. A waiting instruction can then be accepted one cycle after the pulse. If a set and a clear for the same slot happen in the same cycle, the set wins.
- R7: Every handshake produces exactly one `iss_valid` pulse in the following cycle, with `iss_tag` equal to the accepted `in_tag`.
- R8: The controller has no hardware dependency interlock. A pending barrier that is not named in the wait mask does not delay an instruction.
- R9: Index values 6 and 7 on `in_set_idx` or on `done_idx` are ignored and leave `bar_pending` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_ready | output | 1 | Controller can accept this cycle |
| in_tag | input | 8 | Instruction identifier |
| in_stall | input | 4 | Stall code; 0 means the long default wait |
| in_set_en | input | 1 | Instruction marks a barrier slot busy |
| in_set_idx | input | 3 | Barrier slot to mark |
| in_wait_mask | input | 6 | Barrier slots that must be idle before issue |
| done_valid | input | 1 | Completion pulse |
| done_idx | input | 3 | Barrier slot freed by the completion |
| iss_valid | output | 1 | Issue strobe, one cycle after the handshake |
| iss_tag | output | 8 | Tag of the issued instruction |
| bar_pending | output | 6 | Current busy state of each barrier slot |

## Verification
The assertions assume that a handshake only happens while the timer is idle. They also assume that the producer keeps its fields steady while it waits, and that completion pulses last one cycle each and never repeat within a single cycle.

The bench drives the fields once per instruction and holds them until acceptance. It raises `done_valid` only for single cycles, either on schedule or from a pseudo-random sequence.

Directed phases place a set and a clear for the same slot in the same cycle, use out-of-range slot indices, and leave a pending barrier unnamed in the wait mask. A pseudo-random phase then mixes all of these under a per-cycle reference model.

// File: rtl/isc_pkg.sv
package isc_pkg;

  // Fixed sizes of the compiler control fields.
  localparam int unsigned STALL_BITS = 4;
  localparam int unsigned BARRIERS   = 6;

  // Cycles to wait before the next issue; code 0 selects the long default.
  function automatic int unsigned wait_cycles(input int unsigned code,
                                              input int unsigned long_wait);
    return (code == 0) ? long_wait : code;
  endfunction

endpackage

// File: rtl/isc_stall_timer.sv
module isc_stall_timer
  import isc_pkg::*;
#(
  parameter int unsigned STALL_W      = STALL_BITS,
  parameter int unsigned DEFAULT_WAIT = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [STALL_W-1:0] code,
  output logic               busy
);

  localparam int unsigned CODE_MAX = (1 << STALL_W) - 1;
  localparam int unsigned SPAN     = (DEFAULT_WAIT > CODE_MAX) ? DEFAULT_WAIT : CODE_MAX;
  localparam int unsigned CNT_W    = $clog2(SPAN + 1);

  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] load_val;

  // Cycles left after the issue cycle itself.
  always_comb begin
    load_val = CNT_W'(wait_cycles(int'(code), DEFAULT_WAIT) - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain <= '0;
    end else if (load) begin
      remain <= load_val;
    end else if (remain != '0) begin
      remain <= remain - CNT_W'(1);
    end
  end

  assign busy = (remain != '0);

  // R2: a running count steps down by one each cycle
  p_count_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (remain != '0) |=> (remain == $past(remain) - CNT_W'(1)));

  // R2: the issue gate only loads an idle timer
  p_load_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (remain == '0));

  // R3: code zero arms the long wait
  p_long_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && code == '0) |=> (remain == CNT_W'(DEFAULT_WAIT - 1)));

endmodule

// File: rtl/isc_barrier_table.sv
module isc_barrier_table #(
  parameter int unsigned NUM_BAR = 6,
  parameter int unsigned IDX_W   = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               set_en,
  input  logic [IDX_W-1:0]   set_idx,
  input  logic               clr_en,
  input  logic [IDX_W-1:0]   clr_idx,
  output logic [NUM_BAR-1:0] pending
);

  logic [NUM_BAR-1:0] set_hit;
  logic [NUM_BAR-1:0] clr_hit;

  for (genvar i = 0; i < NUM_BAR; i++) begin : g_slot
    assign set_hit[i] = set_en && (set_idx == IDX_W'(i));
    assign clr_hit[i] = clr_en && (clr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        pending[i] <= 1'b0;
      end else if (set_hit[i]) begin
        pending[i] <= 1'b1;
      end else if (clr_hit[i]) begin
        pending[i] <= 1'b0;
      end
    end

    // R6: a set beats a clear for the same slot
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_hit[i] |=> pending[i]);

    // R6: a lone clear frees the slot
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit[i] && !set_hit[i]) |=> !pending[i]);

    // R4: untouched slots keep their state
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_hit[i] && !clr_hit[i]) |=> (pending[i] == $past(pending[i])));
  end

  // R9: out-of-range indices change nothing
  p_bad_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(set_idx) >= NUM_BAR && int'(clr_idx) >= NUM_BAR) |=>
      (pending == $past(pending)));

endmodule

// File: rtl/isc_issue_gate.sv
module isc_issue_gate #(
  parameter int unsigned NUM_BAR = 6
) (
  input  logic               in_valid,
  input  logic [NUM_BAR-1:0] wait_mask,
  input  logic [NUM_BAR-1:0] pending,
  input  logic               timer_busy,
  output logic               ready,
  output logic               fire
);

  logic blocked_by_bar;

  always_comb begin
    blocked_by_bar = |(wait_mask & pending);
    ready          = !timer_busy && !blocked_by_bar;
    fire           = in_valid && ready;
  end

endmodule

// File: rtl/issue_stall_ctrl.sv
module issue_stall_ctrl
  import isc_pkg::*;
#(
  parameter int unsigned TAG_W        = 8,
  parameter int unsigned STALL_W      = STALL_BITS,
  parameter int unsigned NUM_BAR      = BARRIERS,
  parameter int unsigned DEFAULT_WAIT = 32,
  localparam int unsigned IDX_W       = (NUM_BAR > 1) ? $clog2(NUM_BAR) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [TAG_W-1:0]   in_tag,
  input  logic [STALL_W-1:0] in_stall,
  input  logic               in_set_en,
  input  logic [IDX_W-1:0]   in_set_idx,
  input  logic [NUM_BAR-1:0] in_wait_mask,
  input  logic               done_valid,
  input  logic [IDX_W-1:0]   done_idx,
  output logic               iss_valid,
  output logic [TAG_W-1:0]   iss_tag,
  output logic [NUM_BAR-1:0] bar_pending
);

  logic fire;
  logic timer_busy;

  isc_issue_gate #(.NUM_BAR(NUM_BAR)) u_gate (
    .in_valid   (in_valid),
    .wait_mask  (in_wait_mask),
    .pending    (bar_pending),
    .timer_busy (timer_busy),
    .ready      (in_ready),
    .fire       (fire)
  );

  isc_stall_timer #(.STALL_W(STALL_W), .DEFAULT_WAIT(DEFAULT_WAIT)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fire),
    .code  (in_stall),
    .busy  (timer_busy)
  );

  isc_barrier_table #(.NUM_BAR(NUM_BAR), .IDX_W(IDX_W)) u_bars (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (fire && in_set_en),
    .set_idx (in_set_idx),
    .clr_en  (done_valid),
    .clr_idx (done_idx),
    .pending (bar_pending)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iss_valid <= 1'b0;
      iss_tag   <= '0;
    end else begin
      iss_valid <= fire;
      if (fire) iss_tag <= in_tag;
    end
  end

  // R2: a running timer holds back the next instruction
  p_busy_blocks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    timer_busy |-> !in_ready);

  // R5: a pending barrier in the wait mask holds back issue
  p_mask_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|(in_wait_mask & bar_pending)) |-> !in_ready);

  // R7: one strobe carrying the tag follows each handshake
  p_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (iss_valid && iss_tag == $past(in_tag)));

  // R7: no strobe without a handshake
  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> !iss_valid);

endmodule

// File: tb/tb_issue_stall_ctrl.sv
module tb_issue_stall_ctrl;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_tag;
  logic [3:0] in_stall;
  logic       in_set_en;
  logic [2:0] in_set_idx;
  logic [5:0] in_wait_mask;
  logic       done_valid;
  logic [2:0] done_idx;
  logic       iss_valid;
  logic [7:0] iss_tag;
  logic [5:0] bar_pending;

  always #5 clk = ~clk;

  issue_stall_ctrl dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_tag(in_tag), .in_stall(in_stall), .in_set_en(in_set_en),
    .in_set_idx(in_set_idx), .in_wait_mask(in_wait_mask),
    .done_valid(done_valid), .done_idx(done_idx),
    .iss_valid(iss_valid), .iss_tag(iss_tag), .bar_pending(bar_pending)
  );

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  int edges = 0;

  // reference model state
  int         m_cnt;
  logic [5:0] m_pend;
  logic       m_iss;
  logic [7:0] m_tag;

  int         last_fire = 0;
  int         prev_fire = 0;
  int         sched_at  = -1;
  logic [2:0] sched_idx = '0;
  bit         rand_done = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] step_lfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // One clock: compare the combinational ready, advance the model, compare registers.
  task automatic tick(output bit fired);
    bit exp_ready;
    if (rand_done) begin
      lfsr       = step_lfsr(lfsr);
      done_valid = (lfsr[1:0] == 2'b00);
      done_idx   = lfsr[6:4];
    end else begin
      done_valid = (cyc == sched_at);
      done_idx   = sched_idx;
    end
    #1;
    exp_ready = (m_cnt == 0) && ((in_wait_mask & m_pend) == 6'd0);
    chk(in_ready == exp_ready, "R5 ready", int'(in_ready), int'(exp_ready));
    fired = in_valid && exp_ready;
    @(posedge clk);
    if (fired) begin
      m_cnt = ((in_stall == 4'd0) ? 32 : int'(in_stall)) - 1;
    end else if (m_cnt > 0) begin
      m_cnt = m_cnt - 1;
    end
    if (done_valid && done_idx < 3'd6) m_pend[done_idx] = 1'b0;
    if (fired && in_set_en && in_set_idx < 3'd6) m_pend[in_set_idx] = 1'b1;
    m_iss = fired;
    if (fired) begin
      m_tag     = in_tag;
      prev_fire = last_fire;
      last_fire = cyc;
    end
    cyc++;
    @(negedge clk);
    chk(bar_pending == m_pend, "R4 pending", int'(bar_pending), int'(m_pend));
    chk(iss_valid == m_iss, "R7 strobe", int'(iss_valid), int'(m_iss));
    if (m_iss) chk(iss_tag == m_tag, "R7 tag", int'(iss_tag), int'(m_tag));
  endtask

  task automatic idle();
    bit f;
    in_valid = 1'b0;
    tick(f);
  endtask

  task automatic send(input logic [7:0] tag, input logic [3:0] st, input logic se,
                      input logic [2:0] si, input logic [5:0] wm);
    bit f = 1'b0;
    int n = 0;
    in_valid = 1'b1; in_tag = tag; in_stall = st;
    in_set_en = se; in_set_idx = si; in_wait_mask = wm;
    while (!f && n < 600) begin
      tick(f);
      n++;
    end
    if (!f) chk(1'b0, "R2 handshake timeout", n, 0);
    in_valid = 1'b0;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      edges++;
      if (edges > 150000) begin
        chk(1'b0, "watchdog", edges, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_tag = '0; in_stall = 4'd1;
    in_set_en = 1'b0; in_set_idx = '0; in_wait_mask = 6'h3F;
    done_valid = 1'b0; done_idx = '0;
    m_cnt = 0; m_pend = '0; m_iss = 1'b0; m_tag = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: idle after reset, even with every mask bit set
    #1;
    chk(in_ready == 1'b1, "R1 ready", int'(in_ready), 1);
    chk(bar_pending == 6'd0, "R1 pending", int'(bar_pending), 0);
    chk(iss_valid == 1'b0, "R1 strobe", int'(iss_valid), 0);
    @(negedge clk);

    // R2: stall 4 then 1
    send(8'h11, 4'd4, 1'b0, 3'd0, 6'd0);
    send(8'h12, 4'd1, 1'b0, 3'd0, 6'd0);
    chk(last_fire - prev_fire == 4, "R2 gap stall4", last_fire - prev_fire, 4);
    send(8'h13, 4'd1, 1'b0, 3'd0, 6'd0);
    chk(last_fire - prev_fire == 1, "R2 gap stall1", last_fire - prev_fire, 1);

    // R3: code 0 is the long wait
    send(8'h20, 4'd0, 1'b0, 3'd0, 6'd0);
    send(8'h21, 4'd1, 1'b0, 3'd0, 6'd0);
    chk(last_fire - prev_fire == 32, "R3 gap code0", last_fire - prev_fire, 32);

    // R4/R5/R6: barrier 3 blocks until its completion
    send(8'h30, 4'd1, 1'b1, 3'd3, 6'd0);
    chk(bar_pending[3] == 1'b1, "R4 set slot3", int'(bar_pending[3]), 1);
    sched_at = cyc + 5; sched_idx = 3'd3;
    send(8'h31, 4'd1, 1'b0, 3'd0, 6'b001000);
    chk(last_fire == sched_at + 1, "R6 release", last_fire, sched_at + 1);
    chk(bar_pending[3] == 1'b0, "R6 cleared", int'(bar_pending[3]), 0);

    // R8: pending slot 1 not named in mask
    send(8'h40, 4'd1, 1'b1, 3'd1, 6'd0);
    send(8'h41, 4'd1, 1'b0, 3'd0, 6'b000001);
    chk(last_fire - prev_fire == 1, "R8 no interlock", last_fire - prev_fire, 1);

    // R6: set and clear of slot 1 in the same cycle
    sched_at = cyc; sched_idx = 3'd1;
    send(8'h50, 4'd1, 1'b1, 3'd1, 6'd0);
    chk(bar_pending[1] == 1'b1, "R6 set wins", int'(bar_pending[1]), 1);
    sched_at = cyc; sched_idx = 3'd1;
    idle();
    chk(bar_pending[1] == 1'b0, "R6 clear", int'(bar_pending[1]), 0);

    // R9: out-of-range indices
    send(8'h60, 4'd1, 1'b1, 3'd6, 6'd0);
    chk(bar_pending == 6'd0, "R9 set idx6", int'(bar_pending), 0);
    send(8'h61, 4'd1, 1'b1, 3'd0, 6'd0);
    sched_at = cyc; sched_idx = 3'd7;
    idle();
    chk(bar_pending == 6'b000001, "R9 done idx7", int'(bar_pending), 1);
    sched_at = cyc; sched_idx = 3'd0;
    idle();

    // mixed pseudo-random traffic against the model
    rand_done = 1'b1;
    for (int k = 0; k < 400; k++) begin
      lfsr = step_lfsr(lfsr); lfsr = step_lfsr(lfsr);
      send(8'(k), (lfsr[3:0] == 4'd0) ? 4'd0 : {2'b00, lfsr[5:4]},
           lfsr[7], lfsr[10:8], lfsr[15:11] & {lfsr[2], 4'hF} & 6'h3F);
      if (lfsr[12]) idle();
    end
    rand_done = 1'b0;
    repeat (3) idle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule